// File: doc/BRIEF.md
# Gated Multi-Channel Sine/Cosine Integrator

This block measures the in-phase and quadrature response of several signal channels to a sinusoidal excitation. It does not generate the sinusoid. A separate phase generator supplies the cosine and sine samples, a strobe that marks each fresh sample pair, and a strobe that marks each completed turn of the phase. Once triggered, the block waits for the next turn boundary. It then lets a programmed number of whole turns pass as settling time. After that it multiplies every channel sample by the cosine and the sine and sums the products over a programmed number of whole turns.

When the last integration turn closes, the block presents one cosine integral and one sine integral per channel, together with the number of clocks the integration window lasted, and pulses a completion flag. Each accumulator is wider than the product by a set of guard bits. The lowest bits of the sum take part in the additions but are dropped from the reported result. The channel count is fixed when the block is built, between 1 and 15.

Top module: `sincos_integrator`

## Requirements
- R1: During reset and in the cycles after it, `busy`, `done` and `integ_clks` are 0 and every field of `integrals` is 0. `start_pulse` is 0 while `go` is low.
- R2: In a cycle where `go` is high, `rst` is low and the block is idle, `start_pulse` is high in that same cycle. `busy` is high from the next cycle on.
- R3: A `go` that arrives while `busy` is high gives no `start_pulse` and has no effect on the timing, the clock count or the integrals of the sequence already running.
- R4: `damp_turns` and `acq_turns` are captured on the start cycle, so later changes do not affect the running sequence. The first `turn_tick` after the start opens the settling period. The integration window starts in the cycle after the `turn_tick` that ends `damp_turns` further turns. When `damp_turns` is 0, it starts right after that first tick.
- R5: The window closes on the `acq_turns`-th `turn_tick` seen inside it, and an `acq_turns` of 0 acts as 1. `done` is high for exactly the next cycle, and `busy` is low in that same cycle.
- R6: Products are added only in cycles that are inside the window and have `dds_tick` high. This includes a `dds_tick` that falls on the closing `turn_tick`. Inputs are two's complement. The cosine integral sums channel×`dds_cos` and the sine integral sums channel×`dds_sin`.
- R7: Each reported integral is the two's-complement accumulator shifted right arithmetically by APB bits and truncated to WO bits, that is, accumulator bits [APB+WO-1:APB].
- R8: `integ_clks` counts every clock cycle of the integration window, the closing cycle included. Both it and `integrals` hold steady from `done` until the next start.
- R9: Channel k is read from `chan_in[k*WD +: WD]`. Its cosine integral goes to `integrals[2k*WO +: WO]` and its sine integral to `integrals[(2k+1)*WO +: WO]`, and channels do not interact.
- R10: A reset that arrives mid-sequence returns the block to idle with `busy` low from the next cycle. No `done` follows.
- R11: In the cycle after `start_pulse`, `integ_clks` and every integral read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Trigger request |
| turn_tick | input | 1 | One-cycle strobe at each completed phase turn |
| dds_tick | input | 1 | One-cycle strobe marking a fresh cosine/sine sample |
| dds_cos | input | WDDS | Cosine sample, two's complement |
| dds_sin | input | WDDS | Sine sample, two's complement |
| chan_in | input | NCH*WD | Concatenated channel samples, two's complement |
| damp_turns | input | WTC | Settling length in turns |
| acq_turns | input | WTC | Integration length in turns |
| start_pulse | output | 1 | High in the cycle a trigger is accepted |
| busy | output | 1 | Sequence in progress, settling included |
| done | output | 1 | One-cycle completion flag |
| integ_clks | output | WCLK | Clock cycles spent integrating |
| integrals | output | 2*NCH*WO | Cosine and sine integrals per channel |

## Verification
The trigger response is combinational, so `start_pulse` is due in the same cycle as `go`. `busy` and the cleared results are due one clock later. The integration window opens one clock after the qualifying `turn_tick`. `done`, the final integrals and the clock count are due one clock after the closing `turn_tick`. The bench drives every input just after the falling edge and samples outputs 1 ns later. It keeps a per-cycle reference of the sequence state, derived from the requirements and advanced once per rising edge. Each sample is therefore compared against exactly the cycle in which the result falls due.

// File: rtl/sci_pkg.sv
package sci_pkg;

   localparam int SCI_MAX_CHANNELS = 15;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARM   = 2'd1,
      SEQ_DAMP  = 2'd2,
      SEQ_INTEG = 2'd3
   } seq_state_t;

   function automatic int sci_acc_width(input int wx, input int wc, input int guard);
      return wx + wc + guard;
   endfunction

endpackage

// File: rtl/sci_sequencer.sv
module sci_sequencer
   import sci_pkg::*;
#(
   parameter int WTC = 10
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           go,
   input  logic           turn_tick,
   input  logic [WTC-1:0] damp_turns,
   input  logic [WTC-1:0] acq_turns,
   output logic           start_pulse,
   output logic           busy,
   output logic           integ_en,
   output logic           done
);

   localparam int WCNT = WTC + 1;
   localparam logic [WCNT-1:0] CNT_ONE = WCNT'(1);

   seq_state_t     state_q;
   logic [WTC-1:0] cnt_q;
   logic [WTC-1:0] damp_q;
   logic [WTC-1:0] acq_q;
   logic [WCNT-1:0] cnt_next;
   logic           damp_last;
   logic           acq_last;

   assign start_pulse = go && !rst && (state_q == SEQ_IDLE);
   assign busy        = (state_q != SEQ_IDLE);
   assign integ_en    = (state_q == SEQ_INTEG);

   assign cnt_next  = {1'b0, cnt_q} + CNT_ONE;
   assign damp_last = (cnt_next == {1'b0, damp_q});
   assign acq_last  = (cnt_next >= {1'b0, acq_q});

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         damp_q  <= '0;
         acq_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (go) begin
                  state_q <= SEQ_ARM;
                  cnt_q   <= '0;
                  damp_q  <= damp_turns;
                  acq_q   <= acq_turns;
               end
            end
            SEQ_ARM: begin
               if (turn_tick) begin
                  cnt_q   <= '0;
                  state_q <= (damp_q == '0) ? SEQ_INTEG : SEQ_DAMP;
               end
            end
            SEQ_DAMP: begin
               if (turn_tick) begin
                  if (damp_last) begin
                     state_q <= SEQ_INTEG;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_next[WTC-1:0];
                  end
               end
            end
            SEQ_INTEG: begin
               if (turn_tick) begin
                  if (acq_last) begin
                     state_q <= SEQ_IDLE;
                     cnt_q   <= '0;
                     done    <= 1'b1;
                  end else begin
                     cnt_q <= cnt_next[WTC-1:0];
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sci_mac.sv
module sci_mac #(
   parameter int WX  = 15,
   parameter int WC  = 15,
   parameter int OFL = 10,
   parameter int APB = 12,
   parameter int WO  = 24
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 clear,
   input  logic                 en,
   input  logic signed [WX-1:0] x,
   input  logic signed [WC-1:0] c,
   output logic        [WO-1:0] y
);

   localparam int WP = WX + WC;
   localparam int WA = sci_pkg::sci_acc_width(WX, WC, OFL);

   logic signed [WP-1:0] prod;
   logic        [WA-1:0] prod_ext;
   logic        [WA-1:0] acc_q;

   assign prod     = x * c;
   assign prod_ext = {{OFL{prod[WP-1]}}, prod};

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= acc_q + prod_ext;
      end
   end

   generate
      if (APB == 0) begin : g_full
         assign y = acc_q[WO-1:0];
      end else begin : g_drop
         assign y = acc_q[APB +: WO];
      end
   endgenerate

endmodule

// File: rtl/sci_clk_counter.sv
module sci_clk_counter #(
   parameter int WCLK = 24
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clear,
   input  logic            en,
   output logic [WCLK-1:0] count
);

   localparam logic [WCLK-1:0] STEP = WCLK'(1);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         count <= '0;
      end else if (en) begin
         count <= count + STEP;
      end
   end

endmodule

// File: rtl/sincos_integrator.sv
module sincos_integrator
   import sci_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int WD   = 15,
   parameter int WDDS = 15,
   parameter int WO   = 24,
   parameter int OFL  = 10,
   parameter int APB  = 12,
   parameter int WTC  = 10,
   parameter int WCLK = 24
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                go,
   input  logic                turn_tick,
   input  logic                dds_tick,
   input  logic [WDDS-1:0]     dds_cos,
   input  logic [WDDS-1:0]     dds_sin,
   input  logic [NCH*WD-1:0]   chan_in,
   input  logic [WTC-1:0]      damp_turns,
   input  logic [WTC-1:0]      acq_turns,
   output logic                start_pulse,
   output logic                busy,
   output logic                done,
   output logic [WCLK-1:0]     integ_clks,
   output logic [2*NCH*WO-1:0] integrals
);

   localparam int WACC = sci_acc_width(WD, WDDS, OFL);

   generate
      if (NCH < 1 || NCH > SCI_MAX_CHANNELS) begin : g_bad_nch
         $error("sincos_integrator: NCH must lie in 1..15");
      end
      if (OFL < 1) begin : g_bad_ofl
         $error("sincos_integrator: OFL must be at least 1");
      end
      if (APB < 0 || APB + WO > WACC) begin : g_bad_apb
         $error("sincos_integrator: APB + WO exceeds accumulator width");
      end
      if (WTC < 1 || WCLK < 1 || WO < 2) begin : g_bad_width
         $error("sincos_integrator: counter or output width too small");
      end
   endgenerate

   logic integ_en;
   logic mac_en;

   sci_sequencer #(.WTC(WTC)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .go          (go),
      .turn_tick   (turn_tick),
      .damp_turns  (damp_turns),
      .acq_turns   (acq_turns),
      .start_pulse (start_pulse),
      .busy        (busy),
      .integ_en    (integ_en),
      .done        (done)
   );

   assign mac_en = integ_en && dds_tick;

   sci_clk_counter #(.WCLK(WCLK)) u_clks (
      .clk   (clk),
      .rst   (rst),
      .clear (start_pulse),
      .en    (integ_en),
      .count (integ_clks)
   );

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_chan
         logic signed [WD-1:0] x_k;
         assign x_k = chan_in[k*WD +: WD];

         for (genvar p = 0; p < 2; p++) begin : g_part
            logic signed [WDDS-1:0] ref_p;
            assign ref_p = (p == 0) ? dds_cos : dds_sin;

            sci_mac #(
               .WX  (WD),
               .WC  (WDDS),
               .OFL (OFL),
               .APB (APB),
               .WO  (WO)
            ) u_mac (
               .clk   (clk),
               .rst   (rst),
               .clear (start_pulse),
               .en    (mac_en),
               .x     (x_k),
               .c     (ref_p),
               .y     (integrals[(2*k+p)*WO +: WO])
            );
         end
      end
   endgenerate

endmodule

// File: rtl/sci_checker.sv
module sci_checker #(
   parameter int NCH  = 2,
   parameter int WO   = 24,
   parameter int WCLK = 24
) (
   input logic                clk,
   input logic                rst,
   input logic                go,
   input logic                start_pulse,
   input logic                busy,
   input logic                done,
   input logic [WCLK-1:0]     integ_clks,
   input logic [2*NCH*WO-1:0] integrals
);

   // R2: an accepted trigger needs go and leads to busy
   a_r2_start_needs_go: assert property (@(posedge clk) disable iff (rst)
      start_pulse |-> go);
   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
      start_pulse |=> busy);

   // R3: no trigger is accepted while a sequence runs
   a_r3_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
      busy |-> !start_pulse);

   // R5: done is a single cycle and coincides with the end of busy
   a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   a_r5_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> done);

   // R10: a reset leaves the block idle with no completion
   a_r10_reset_idle: assert property (@(posedge clk)
      $past(rst) |-> (!busy && !done));

   // R11: results are cleared when a sequence starts
   a_r11_clear_on_start: assert property (@(posedge clk) disable iff (rst)
      start_pulse |=> (integ_clks == '0 && integrals == '0));

   // R8: results hold while idle
   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      (!busy && !$past(busy) && !$past(start_pulse) && !$past(rst))
      |-> ($stable(integ_clks) && $stable(integrals)));

endmodule

bind sincos_integrator sci_checker #(
   .NCH  (NCH),
   .WO   (WO),
   .WCLK (WCLK)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .go          (go),
   .start_pulse (start_pulse),
   .busy        (busy),
   .done        (done),
   .integ_clks  (integ_clks),
   .integrals   (integrals)
);

// File: tb/sincos_integrator_bench.sv
`timescale 1ns/1ps
module sincos_integrator_bench;

   localparam int NCH  = 3;
   localparam int WD   = 15;
   localparam int WDDS = 15;
   localparam int WO   = 24;
   localparam int OFL  = 10;
   localparam int APB  = 4;
   localparam int WTC  = 10;
   localparam int WCLK = 16;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                go = 1'b0;
   logic                turn_tick = 1'b0;
   logic                dds_tick = 1'b0;
   logic [WDDS-1:0]     dds_cos = '0;
   logic [WDDS-1:0]     dds_sin = '0;
   logic [NCH*WD-1:0]   chan_in = '0;
   logic [WTC-1:0]      damp_turns = '0;
   logic [WTC-1:0]      acq_turns = '0;
   logic                start_pulse;
   logic                busy;
   logic                done;
   logic [WCLK-1:0]     integ_clks;
   logic [2*NCH*WO-1:0] integrals;

   always #10 clk = ~clk;

   sincos_integrator #(
      .NCH(NCH), .WD(WD), .WDDS(WDDS), .WO(WO),
      .OFL(OFL), .APB(APB), .WTC(WTC), .WCLK(WCLK)
   ) u_sincos_integrator (
      .clk(clk), .rst(rst), .go(go), .turn_tick(turn_tick), .dds_tick(dds_tick),
      .dds_cos(dds_cos), .dds_sin(dds_sin), .chan_in(chan_in),
      .damp_turns(damp_turns), .acq_turns(acq_turns),
      .start_pulse(start_pulse), .busy(busy), .done(done),
      .integ_clks(integ_clks), .integrals(integrals)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int cyc = 0;

   // reference state, advanced once per rising edge
   int     m_state = 0;
   int     m_cnt = 0;
   int     m_damp = 0;
   int     m_acq = 0;
   int     m_clks = 0;
   longint m_si [NCH];
   longint m_sq [NCH];
   bit     m_done_exp = 0;
   bit     m_chk_clear = 0;
   bit     seen_done = 0;
   int     done_err = 0, busy_err = 0, sp_err = 0, clr_err = 0;

   task automatic chk(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_errs();
      done_err = 0; busy_err = 0; sp_err = 0; clr_err = 0; seen_done = 0;
   endtask

   task automatic step(input logic g, input logic r);
      int cv, sv;
      int xv [NCH];
      bit tt, dt, exp_sp;
      @(negedge clk);
      cyc++;
      tt = (cyc % 16 == 5);
      dt = (cyc % 3 == 0);
      cv = (cyc * 37) % 200 - 100;
      sv = (cyc * 53) % 180 - 90;
      go = g; rst = r; turn_tick = tt; dds_tick = dt;
      dds_cos = WDDS'(cv);
      dds_sin = WDDS'(sv);
      for (int k = 0; k < NCH; k++) begin
         xv[k] = (cyc * (11 + 7 * k) + k * 29) % 300 - 150;
         chan_in[k*WD +: WD] = WD'(xv[k]);
      end
      #1;
      if (done !== m_done_exp) done_err++;
      if (m_done_exp && done === 1'b1) seen_done = 1;
      if (busy !== (m_state != 0)) busy_err++;
      exp_sp = g && !r && (m_state == 0);
      if (start_pulse !== exp_sp) sp_err++;
      if (m_chk_clear) begin
         if (integ_clks !== '0) clr_err++;
         if (integrals !== '0) clr_err++;
         m_chk_clear = 0;
      end
      m_done_exp = 0;
      if (r) begin
         m_state = 0; m_cnt = 0; m_clks = 0;
         for (int k = 0; k < NCH; k++) begin m_si[k] = 0; m_sq[k] = 0; end
      end else begin
         case (m_state)
            0: if (g) begin
                  m_state = 1; m_cnt = 0; m_clks = 0; m_chk_clear = 1;
                  for (int k = 0; k < NCH; k++) begin m_si[k] = 0; m_sq[k] = 0; end
               end
            1: if (tt) begin
                  m_cnt = 0;
                  m_state = (m_damp == 0) ? 3 : 2;
               end
            2: if (tt) begin
                  m_cnt++;
                  if (m_cnt == m_damp) begin m_state = 3; m_cnt = 0; end
               end
            default: begin
               m_clks++;
               if (dt) begin
                  for (int k = 0; k < NCH; k++) begin
                     m_si[k] += longint'(xv[k]) * longint'(cv);
                     m_sq[k] += longint'(xv[k]) * longint'(sv);
                  end
               end
               if (tt) begin
                  m_cnt++;
                  if (m_cnt >= ((m_acq == 0) ? 1 : m_acq)) begin
                     m_state = 0; m_cnt = 0; m_done_exp = 1;
                  end
               end
            end
         endcase
      end
   endtask

   task automatic check_results(input string tag);
      logic [WO-1:0] e_i, e_q, a_i, a_q;
      chk({tag, " R4 R8 integ_clks"}, integ_clks == WCLK'(m_clks), integ_clks, m_clks);
      for (int k = 0; k < NCH; k++) begin
         e_i = WO'(m_si[k] >>> APB);
         e_q = WO'(m_sq[k] >>> APB);
         a_i = integrals[(2*k)*WO +: WO];
         a_q = integrals[(2*k+1)*WO +: WO];
         chk({tag, " R6 R7 R9 cosine integral"}, a_i == e_i, a_i, e_i);
         chk({tag, " R6 R7 R9 sine integral"}, a_q == e_q, a_q, e_q);
      end
   endtask

   task automatic run_seq(input int damp, input int acq, input bit go_busy,
                          input bit chg_cfg, input string tag);
      bit g;
      clear_errs();
      damp_turns = WTC'(damp);
      acq_turns  = WTC'(acq);
      m_damp = damp;
      m_acq  = acq;
      step(1'b1, 1'b0);
      for (int i = 0; i < 2000 && !seen_done; i++) begin
         if (chg_cfg && i == 2) begin
            damp_turns = WTC'(damp + 3);
            acq_turns  = WTC'(acq + 2);
         end
         g = go_busy && (i % 7 == 3) && (m_state != 0);
         step(g, 1'b0);
      end
      chk({tag, " R2 R3 start_pulse"}, sp_err == 0, sp_err, 0);
      chk({tag, " R2 busy"}, busy_err == 0, busy_err, 0);
      chk({tag, " R5 done timing"}, done_err == 0 && seen_done, done_err, 0);
      chk({tag, " R11 clear at start"}, clr_err == 0, clr_err, 0);
      check_results(tag);
   endtask

   task automatic t_reset();
      clear_errs();
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      chk("R1 busy after reset", busy === 1'b0, busy, 0);
      chk("R1 done after reset", done === 1'b0, done, 0);
      chk("R1 start_pulse idle", start_pulse === 1'b0, start_pulse, 0);
      chk("R1 integ_clks zero", integ_clks === '0, integ_clks, 0);
      chk("R1 integrals zero", integrals === '0, (integrals === '0) ? 0 : 1, 0);
   endtask

   task automatic t_basic();
      run_seq(2, 3, 1'b0, 1'b0, "basic");
   endtask

   task automatic t_zero_damp();
      run_seq(0, 1, 1'b0, 1'b0, "zero damp R4");
   endtask

   task automatic t_zero_acq();
      run_seq(1, 0, 1'b0, 1'b0, "zero acq R5");
   endtask

   task automatic t_go_busy();
      run_seq(1, 2, 1'b1, 1'b1, "go while busy R3 R4");
   endtask

   task automatic t_hold();
      logic [WCLK-1:0]     c0;
      logic [2*NCH*WO-1:0] v0;
      clear_errs();
      c0 = integ_clks;
      v0 = integrals;
      for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
      chk("R8 integ_clks held", integ_clks == c0, integ_clks, c0);
      chk("R8 integrals held", integrals == v0, (integrals == v0) ? 0 : 1, 0);
      chk("R8 no done while idle", done_err == 0, done_err, 0);
   endtask

   task automatic t_reset_mid();
      clear_errs();
      damp_turns = WTC'(1);
      acq_turns  = WTC'(6);
      m_damp = 1;
      m_acq  = 6;
      step(1'b1, 1'b0);
      for (int i = 0; i < 45; i++) step(1'b0, 1'b0);
      chk("R10 integrating before reset", busy === 1'b1, busy, 1);
      step(1'b0, 1'b1);
      for (int i = 0; i < 30; i++) step(1'b0, 1'b0);
      chk("R10 busy tracks reset", busy_err == 0, busy_err, 0);
      chk("R10 no done after reset", done_err == 0 && !seen_done, done_err, 0);
      chk("R10 R1 integ_clks cleared", integ_clks === '0, integ_clks, 0);
      chk("R10 R1 integrals cleared", integrals === '0, (integrals === '0) ? 0 : 1, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      for (int k = 0; k < NCH; k++) begin m_si[k] = 0; m_sq[k] = 0; end
      t_reset();
      t_basic();
      t_hold();
      t_basic();
      t_zero_damp();
      t_zero_acq();
      t_go_busy();
      t_reset_mid();
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
      if (!finished) begin
         finished = 1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL R5 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule